// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Reserved Entries

This block is a fully associative address translation buffer of 16 entries, filled and inspected by system software rather than by hardware. Software loads a small set of staging registers (a selector, two half-page descriptors, a page-size mask and a virtual page/address-space tag), then issues one of four operations: store the staging registers into the selected entry, store them into a pseudo-random entry, load an entry back into the staging registers, or search the buffer for the staged tag. Each entry maps an even/odd pair of pages whose size is set per entry by a mask.

A lower group of entries can be reserved by a boundary register. The random victim counter steps down once per cycle and never points below that boundary, so random replacement leaves reserved translations alone. A failed search is reported in the top bit of the selector register. An optional combinational lookup port translates a virtual address using the current address-space tag.

Top module: `sw_tlb`

## Requirements
- R1: While reset is held, Index (register 0) reads 0, Random (register 1) reads 15, Wired (register 6) reads 0, and EntryLo0/EntryLo1/PageMask/EntryHi (registers 2, 3, 5, 10) read 0.
- R2: Register writes keep only the implemented fields: Index bits [3:0] (a write clears bit 31), EntryLo bits [25:0] (PFN [25:6], cache attribute [5:3], dirty [2], valid [1], global [0]), PageMask bits [28:13], EntryHi bits [31:13] (VPN2) and [7:0] (ASID), Wired bits [3:0]. Random is read-only, and unused register numbers read 0.
- R3: Random steps down by one on every clock edge; on the edge after it equals Wired it returns to 15. A write to Wired sets Random to 15 on the same edge.
- R4: Operation code 0 (write-indexed) stores the staging registers into the entry selected by Index.
- R5: Operation code 2 (read) loads the entry selected by Index into the staging registers bit for bit; the global bit reads back in both EntryLo registers as the AND of the two global bits written.
- R6: Operation code 1 (write-random) stores the staging registers into the entry named by Random at that edge, which is always at least Wired.
- R7: Operation code 3 (probe) on a match writes the matching entry number into Index and clears Index bit 31; when several entries match, the lowest number wins.
- R8: A probe with no match sets Index bit 31 and leaves Index bits [3:0] unchanged.
- R9: An entry matches when EntryHi VPN2 equals the entry VPN2 on every bit whose PageMask bit (mask bit i covers VPN2 bit i) is 0, and either the ASIDs are equal or the entry's global bit is 1.
- R10: The lookup port hits when an entry matches the address's VPN2 with EntryHi's ASID and the selected half is valid; the odd half is chosen by the address bit just above the page offset (bit 12 plus the number of mask ones), and the physical address is {PFN,12'h000} with the offset bits {mask,12'hFFF} taken from the virtual address.
- R11: When an operation and a register write touch the same register in one cycle, the operation's result is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register number for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| op_valid | input | 1 | Issue the operation in op_kind this cycle |
| op_kind | input | 2 | 0 write-indexed, 1 write-random, 2 read, 3 probe |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found and valid |
| lk_paddr | output | 32 | Translated physical address (0 without a hit) |
| lk_dirty | output | 1 | Dirty bit of the selected half |
| lk_cattr | output | 3 | Cache attribute of the selected half |

## Verification
On every cycle the assertions hold the victim counter inside the range from Wired to 15, check its single-step descent and its return to 15 after a Wired write, tie each probe outcome to the Index value on the next edge, and require every lookup hit to rest on a real tag match. What the assertions cannot see is whether entries keep their contents, so the bench's scenarios carry the bit-exact read-back, the global-bit folding, the effect of the page mask and of overlapping matches on probe results, the choice of even or odd half, and the precedence of an operation over a same-cycle register write.

// File: rtl/sw_tlb_pkg.sv
package sw_tlb_pkg;

  localparam int VPN2_W  = 19;
  localparam int ASID_W  = 8;
  localparam int PMASK_W = 16;
  localparam int PFN_W   = 20;
  localparam int LO_W    = PFN_W + 6;

  localparam logic [4:0] RA_INDEX  = 5'd0;
  localparam logic [4:0] RA_RANDOM = 5'd1;
  localparam logic [4:0] RA_LO0    = 5'd2;
  localparam logic [4:0] RA_LO1    = 5'd3;
  localparam logic [4:0] RA_PMASK  = 5'd5;
  localparam logic [4:0] RA_WIRED  = 5'd6;
  localparam logic [4:0] RA_HI     = 5'd10;

  typedef enum logic [1:0] {
    OP_WR_IDX = 2'd0,
    OP_WR_RND = 2'd1,
    OP_READ   = 2'd2,
    OP_PROBE  = 2'd3
  } op_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic [2:0]       cattr;
    logic             dirty;
    logic             valid;
  } half_t;

  typedef struct packed {
    logic [VPN2_W-1:0]  vpn2;
    logic [ASID_W-1:0]  asid;
    logic [PMASK_W-1:0] pmask;
    logic               glob;
    half_t              even;
    half_t              odd;
  } ent_t;

  // Page-number comparison with the mask-covered bits left out.
  function automatic logic vpn_eq(input logic [VPN2_W-1:0] a,
                                  input logic [VPN2_W-1:0] b,
                                  input logic [PMASK_W-1:0] m);
    logic [VPN2_W-1:0] care;
    care = ~{{(VPN2_W-PMASK_W){1'b0}}, m};
    return ((a ^ b) & care) == '0;
  endfunction

  function automatic logic ent_match(input ent_t e,
                                     input logic [VPN2_W-1:0] v,
                                     input logic [ASID_W-1:0] asid);
    return vpn_eq(v, e.vpn2, e.pmask) && (e.glob || (e.asid == asid));
  endfunction

  // Bit that chooses the odd half: just above the page offset.
  function automatic logic odd_pick(input logic [31:0] va,
                                    input logic [PMASK_W-1:0] m);
    logic s;
    s = va[12];
    for (int i = 0; i < PMASK_W; i++)
      if (m[i]) s = va[13+i];
    return s;
  endfunction

  function automatic logic [31:0] offset_mask(input logic [PMASK_W-1:0] m);
    return {4'b0, m, 12'hFFF};
  endfunction

  function automatic logic [31:0] phys_addr(input logic [PFN_W-1:0] pfn,
                                            input logic [31:0] va,
                                            input logic [PMASK_W-1:0] m);
    logic [31:0] om;
    om = offset_mask(m);
    return ({pfn, 12'h000} & ~om) | (va & om);
  endfunction

endpackage

// File: rtl/sw_tlb_first.sv
module sw_tlb_first #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  // Lowest set position wins.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/sw_tlb_regs.sv
module sw_tlb_regs
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [4:0]           cfg_addr,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 ld_entry,
  input  ent_t                 ld_data,
  input  logic                 pr_done,
  input  logic                 pr_hit,
  input  logic [IDX_W-1:0]     pr_idx,
  output logic                 index_p,
  output logic [IDX_W-1:0]     index_idx,
  output logic [IDX_W-1:0]     rnd_q,
  output logic [IDX_W-1:0]     wired_q,
  output logic                 wired_we,
  output logic [LO_W-1:0]      lo0_q,
  output logic [LO_W-1:0]      lo1_q,
  output logic [PMASK_W-1:0]   pmask_q,
  output logic [VPN2_W-1:0]    vpn2_q,
  output logic [ASID_W-1:0]    asid_q
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_ENT - 1);

  logic we_index, we_lo0, we_lo1, we_pmask, we_hi;
  logic unused_wdata;

  assign we_index = cfg_we && (cfg_addr == RA_INDEX);
  assign we_lo0   = cfg_we && (cfg_addr == RA_LO0);
  assign we_lo1   = cfg_we && (cfg_addr == RA_LO1);
  assign we_pmask = cfg_we && (cfg_addr == RA_PMASK);
  assign we_hi    = cfg_we && (cfg_addr == RA_HI);
  assign wired_we = cfg_we && (cfg_addr == RA_WIRED);
  assign unused_wdata = ^cfg_wdata;

  // Selector: probe result takes precedence over a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_p   <= 1'b0;
      index_idx <= '0;
    end else if (pr_done) begin
      if (pr_hit) begin
        index_p   <= 1'b0;
        index_idx <= pr_idx;
      end else begin
        index_p   <= 1'b1;
      end
    end else if (we_index) begin
      index_p   <= 1'b0;
      index_idx <= cfg_wdata[IDX_W-1:0];
    end
  end

  // Reserved-entry boundary and the descending victim counter.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wired_q <= '0;
      rnd_q   <= IDX_MAX;
    end else begin
      if (wired_we) wired_q <= cfg_wdata[IDX_W-1:0];
      if (wired_we || (rnd_q <= wired_q)) rnd_q <= IDX_MAX;
      else                                rnd_q <= rnd_q - 1'b1;
    end
  end

  // Staging registers: an entry load takes precedence over a software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo0_q   <= '0;
      lo1_q   <= '0;
      pmask_q <= '0;
      vpn2_q  <= '0;
      asid_q  <= '0;
    end else if (ld_entry) begin
      lo0_q   <= {ld_data.even, ld_data.glob};
      lo1_q   <= {ld_data.odd,  ld_data.glob};
      pmask_q <= ld_data.pmask;
      vpn2_q  <= ld_data.vpn2;
      asid_q  <= ld_data.asid;
    end else begin
      if (we_lo0)   lo0_q   <= cfg_wdata[LO_W-1:0];
      if (we_lo1)   lo1_q   <= cfg_wdata[LO_W-1:0];
      if (we_pmask) pmask_q <= cfg_wdata[13+PMASK_W-1:13];
      if (we_hi) begin
        vpn2_q <= cfg_wdata[31:32-VPN2_W];
        asid_q <= cfg_wdata[ASID_W-1:0];
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      RA_INDEX:  cfg_rdata = {index_p, 31'(index_idx)};
      RA_RANDOM: cfg_rdata = 32'(rnd_q);
      RA_LO0:    cfg_rdata = 32'(lo0_q);
      RA_LO1:    cfg_rdata = 32'(lo1_q);
      RA_PMASK:  cfg_rdata = {3'b0, pmask_q, 13'b0};
      RA_WIRED:  cfg_rdata = 32'(wired_q);
      RA_HI:     cfg_rdata = {vpn2_q, 5'b0, asid_q};
      default:   cfg_rdata = 32'h0;
    endcase
  end
endmodule

// File: rtl/sw_tlb_array.sv
module sw_tlb_array
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENT   = 16,
  parameter int IDX_W     = 4,
  parameter bit LOOKUP_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  ent_t                wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output ent_t                rd_data,
  input  logic [VPN2_W-1:0]   pr_vpn2,
  input  logic [ASID_W-1:0]   cur_asid,
  output logic [NUM_ENT-1:0]  pr_match,
  input  logic [VPN2_W-1:0]   lk_vpn2,
  output logic [NUM_ENT-1:0]  lk_match,
  input  logic [IDX_W-1:0]    lk_idx,
  output ent_t                lk_data
);
  ent_t ents [NUM_ENT];

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    ent_t ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ent_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))   ent_q <= wr_data;
    end
    assign ents[g]     = ent_q;
    assign pr_match[g] = ent_match(ent_q, pr_vpn2, cur_asid);
    if (LOOKUP_EN) begin : g_lk
      assign lk_match[g] = ent_match(ent_q, lk_vpn2, cur_asid);
    end else begin : g_nolk
      assign lk_match[g] = 1'b0;
    end
  end

  assign rd_data = ents[rd_idx];
  assign lk_data = ents[lk_idx];
endmodule

// File: rtl/sw_tlb.sv
module sw_tlb
  import sw_tlb_pkg::*;
#(
  parameter int NUM_ENT   = 16,
  parameter bit LOOKUP_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [4:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        op_valid,
  input  logic [1:0]  op_kind,
  input  logic [31:0] lk_vaddr,
  output logic        lk_hit,
  output logic [31:0] lk_paddr,
  output logic        lk_dirty,
  output logic [2:0]  lk_cattr
);
  localparam int IDX_W = $clog2(NUM_ENT);

  op_e kind;
  logic ev_wr_idx, ev_wr_rand, ev_read, ev_probe, ev_probe_hit, ev_probe_miss;
  logic index_p, wired_we;
  logic [IDX_W-1:0] index_idx, rnd_q, wired_q, pr_idx, lk_idx, wr_idx;
  logic [LO_W-1:0] lo0_q, lo1_q;
  logic [PMASK_W-1:0] pmask_q;
  logic [VPN2_W-1:0] vpn2_q;
  logic [ASID_W-1:0] asid_q;
  logic [NUM_ENT-1:0] pr_match, lk_match;
  logic pr_any, lk_any, lk_odd;
  ent_t wr_data, rd_data, lk_data;
  half_t lk_half;

  // Operation events, named for the checker.
  assign kind          = op_e'(op_kind);
  assign ev_wr_idx     = op_valid && (kind == OP_WR_IDX);
  assign ev_wr_rand    = op_valid && (kind == OP_WR_RND);
  assign ev_read       = op_valid && (kind == OP_READ);
  assign ev_probe      = op_valid && (kind == OP_PROBE);
  assign ev_probe_hit  = ev_probe && pr_any;
  assign ev_probe_miss = ev_probe && !pr_any;

  assign wr_idx = ev_wr_rand ? rnd_q : index_idx;

  always_comb begin
    wr_data       = '0;
    wr_data.vpn2  = vpn2_q;
    wr_data.asid  = asid_q;
    wr_data.pmask = pmask_q;
    wr_data.glob  = lo0_q[0] & lo1_q[0];
    wr_data.even  = half_t'(lo0_q[LO_W-1:1]);
    wr_data.odd   = half_t'(lo1_q[LO_W-1:1]);
  end

  sw_tlb_regs #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ld_entry(ev_read), .ld_data(rd_data),
    .pr_done(ev_probe), .pr_hit(pr_any), .pr_idx(pr_idx),
    .index_p(index_p), .index_idx(index_idx),
    .rnd_q(rnd_q), .wired_q(wired_q), .wired_we(wired_we),
    .lo0_q(lo0_q), .lo1_q(lo1_q), .pmask_q(pmask_q),
    .vpn2_q(vpn2_q), .asid_q(asid_q)
  );

  sw_tlb_array #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .LOOKUP_EN(LOOKUP_EN)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ev_wr_idx || ev_wr_rand), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(index_idx), .rd_data(rd_data),
    .pr_vpn2(vpn2_q), .cur_asid(asid_q), .pr_match(pr_match),
    .lk_vpn2(lk_vaddr[31:32-VPN2_W]), .lk_match(lk_match),
    .lk_idx(lk_idx), .lk_data(lk_data)
  );

  sw_tlb_first #(.N(NUM_ENT), .W(IDX_W)) u_pr_first (
    .vec(pr_match), .any(pr_any), .idx(pr_idx)
  );

  sw_tlb_first #(.N(NUM_ENT), .W(IDX_W)) u_lk_first (
    .vec(lk_match), .any(lk_any), .idx(lk_idx)
  );

  // Lookup port: half selection and address assembly.
  assign lk_odd   = odd_pick(lk_vaddr, lk_data.pmask);
  assign lk_half  = lk_odd ? lk_data.odd : lk_data.even;
  assign lk_hit   = lk_any && lk_half.valid;
  assign lk_paddr = lk_hit ? phys_addr(lk_half.pfn, lk_vaddr, lk_data.pmask) : 32'h0;
  assign lk_dirty = lk_hit && lk_half.dirty;
  assign lk_cattr = lk_hit ? lk_half.cattr : 3'b000;
endmodule

// File: rtl/sw_tlb_chk.sv
module sw_tlb_chk #(
  parameter int NUM_ENT = 16,
  parameter int IDX_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rnd,
  input logic [IDX_W-1:0] wired,
  input logic             wired_we,
  input logic             ev_wr_rand,
  input logic             ev_probe_hit,
  input logic             ev_probe_miss,
  input logic [IDX_W-1:0] probe_idx,
  input logic             index_p,
  input logic [IDX_W-1:0] index_idx,
  input logic             lk_hit,
  input logic             lk_any
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_ENT - 1);

  a_r3_rand_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rnd >= wired);

  a_r3_rand_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!wired_we && (rnd > wired)) |=> (rnd == $past(rnd) - 1'b1));

  a_r3_rand_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_we || (rnd == wired)) |=> (rnd == IDX_MAX));

  a_r6_victim_unreserved: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_rand |-> (rnd >= wired));

  a_r7_probe_hit: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_hit |=> (!index_p && (index_idx == $past(probe_idx))));

  a_r8_probe_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ev_probe_miss |=> (index_p && (index_idx == $past(index_idx))));

  a_r10_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_any);
endmodule

bind sw_tlb sw_tlb_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rnd(rnd_q), .wired(wired_q), .wired_we(wired_we),
  .ev_wr_rand(ev_wr_rand), .ev_probe_hit(ev_probe_hit),
  .ev_probe_miss(ev_probe_miss), .probe_idx(pr_idx),
  .index_p(index_p), .index_idx(index_idx),
  .lk_hit(lk_hit), .lk_any(lk_any)
);

// File: tb/test_sw_tlb.sv
module test_sw_tlb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] A_IDX = 5'd0, A_RND = 5'd1, A_LO0 = 5'd2, A_LO1 = 5'd3,
                         A_PM = 5'd5, A_WIR = 5'd6, A_HI = 5'd10;

  // Probe vectors: {EntryHi to probe, expected Index word} with Index preset to 7.
  localparam logic [63:0] PROBE_TAB [10] = '{
    {32'h00010064, 32'h00000002},
    {32'h0001E064, 32'h00000002},
    {32'h00018064, 32'h00000002},
    {32'h00010065, 32'h80000007},
    {32'h00400005, 32'h00000005},
    {32'h004000AA, 32'h00000005},
    {32'h00402005, 32'h80000007},
    {32'h12346011, 32'h00000009},
    {32'h12346012, 32'h80000007},
    {32'h00020064, 32'h80000007}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = '0;
  logic [31:0] lk_vaddr = '0, lk_paddr;
  logic lk_hit, lk_dirty;
  logic [2:0] lk_cattr;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_tlb i_sw_tlb (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .op_valid(op_valid),
    .op_kind(op_kind), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_dirty(lk_dirty), .lk_cattr(lk_cattr)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
    cfg_addr = a;
    #1 v = cfg_rdata;
  endtask

  task automatic do_op(input logic [1:0] k);
    op_valid = 1'b1; op_kind = k;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic put_ent(input logic [31:0] idx, input logic [31:0] hi, input logic [31:0] pm,
                         input logic [31:0] lo0, input logic [31:0] lo1);
    wr_reg(A_HI, hi); wr_reg(A_PM, pm); wr_reg(A_LO0, lo0); wr_reg(A_LO1, lo1);
    wr_reg(A_IDX, idx);
    do_op(2'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_r, r;
    @(negedge clk); @(negedge clk);
    // R1: reset state, observed while reset is held
    rd_reg(A_IDX, v); check("R1 index", v, 32'h0);
    rd_reg(A_RND, v); check("R1 random", v, 32'hF);
    rd_reg(A_WIR, v); check("R1 wired", v, 32'h0);
    rd_reg(A_LO0, v); check("R1 lo0", v, 32'h0);
    rd_reg(A_HI, v);  check("R1 hi", v, 32'h0);
    @(negedge clk); rst_n = 1'b1; @(negedge clk);

    // R2: implemented field masks, read-only and unmapped registers
    wr_reg(A_LO0, 32'hFFFFFFFF); rd_reg(A_LO0, v); check("R2 lo0 mask", v, 32'h03FFFFFF);
    wr_reg(A_PM, 32'hFFFFFFFF);  rd_reg(A_PM, v);  check("R2 pmask mask", v, 32'h1FFFE000);
    wr_reg(A_HI, 32'hFFFFFFFF);  rd_reg(A_HI, v);  check("R2 hi mask", v, 32'hFFFFE0FF);
    wr_reg(A_IDX, 32'hFFFFFFFF); rd_reg(A_IDX, v); check("R2 index mask", v, 32'h0000000F);
    wr_reg(5'd4, 32'h12345678);  rd_reg(5'd4, v);  check("R2 unmapped", v, 32'h0);
    wr_reg(A_LO0, 0); wr_reg(A_PM, 0); wr_reg(A_HI, 0);

    // R3: Random trace after a Wired write, with an ignored write to Random
    wr_reg(A_WIR, 32'd4);
    exp_r = 32'd15;
    rd_reg(A_RND, v); check("R3 random reload", v, exp_r);
    for (int k = 0; k < 14; k++) begin
      if (k == 3) begin cfg_we = 1'b1; cfg_addr = A_RND; cfg_wdata = 32'h0; end
      @(negedge clk);
      cfg_we = 1'b0;
      exp_r = (exp_r <= 32'd4) ? 32'd15 : exp_r - 1;
      rd_reg(A_RND, v); check("R3 random step", v, exp_r);
    end

    // R6: write-random lands at Random, never below Wired
    wr_reg(A_WIR, 32'd8);
    wr_reg(A_LO1, 32'h0);
    for (int t = 0; t < 3; t++) begin
      repeat (t * 2 + 1) @(negedge clk);
      wr_reg(A_HI, 32'h70000020 + (32'(t) << 13));
      wr_reg(A_LO0, 32'h00000102 + (32'(t) << 6));
      cfg_addr = A_RND;
      #1 r = cfg_rdata;
      op_valid = 1'b1; op_kind = 2'd1;
      @(negedge clk); op_valid = 1'b0;
      check("R6 victim at or above wired", 32'(r >= 32'd8), 32'd1);
      wr_reg(A_IDX, 32'd0);
      do_op(2'd3);
      rd_reg(A_IDX, v); check("R6 entry at random", v, r);
    end
    wr_reg(A_WIR, 32'd0);

    // R4/R5: indexed writes and bit-exact read-back
    put_ent(2,  32'h00010064, 32'h0001E000, 32'h0200003E, 32'h0200043E);
    put_ent(5,  32'h00400005, 32'h00000000, 32'h0000103F, 32'h0000107F);
    put_ent(9,  32'h12346011, 32'h00000000, 32'h00000002, 32'h00000000);
    put_ent(12, 32'h00018064, 32'h00000000, 32'h00000001, 32'h00000001);
    put_ent(14, 32'h55554000, 32'h00000000, 32'h00000041, 32'h00000080);
    wr_reg(A_LO0, 0); wr_reg(A_LO1, 0); wr_reg(A_PM, 0); wr_reg(A_HI, 0);
    wr_reg(A_IDX, 32'd2); do_op(2'd2);
    rd_reg(A_LO0, v); check("R4 R5 lo0", v, 32'h0200003E);
    rd_reg(A_LO1, v); check("R4 R5 lo1", v, 32'h0200043E);
    rd_reg(A_PM, v);  check("R4 R5 pmask", v, 32'h0001E000);
    rd_reg(A_HI, v);  check("R4 R5 hi", v, 32'h00010064);
    wr_reg(A_IDX, 32'd14); do_op(2'd2);
    rd_reg(A_LO0, v); check("R5 global and lo0", v, 32'h00000040);
    rd_reg(A_LO1, v); check("R5 global and lo1", v, 32'h00000080);

    // R11: operation wins over a same-cycle register write
    wr_reg(A_IDX, 32'd5);
    cfg_we = 1'b1; cfg_addr = A_LO0; cfg_wdata = 32'h00001234;
    op_valid = 1'b1; op_kind = 2'd2;
    @(negedge clk); cfg_we = 1'b0; op_valid = 1'b0;
    rd_reg(A_LO0, v); check("R11 read over lo0 write", v, 32'h0000103F);
    cfg_we = 1'b1; cfg_addr = A_IDX; cfg_wdata = 32'd3;
    op_valid = 1'b1; op_kind = 2'd3;
    @(negedge clk); cfg_we = 1'b0; op_valid = 1'b0;
    rd_reg(A_IDX, v); check("R11 probe over index write", v, 32'h00000005);

    // R7/R8/R9: probe vector table
    foreach (PROBE_TAB[i]) begin
      wr_reg(A_HI, PROBE_TAB[i][63:32]);
      wr_reg(A_IDX, 32'd7);
      do_op(2'd3);
      rd_reg(A_IDX, v);
      check($sformatf("R7 R8 R9 probe row %0d", i), v, PROBE_TAB[i][31:0]);
    end

    // R10: lookup port
    wr_reg(A_HI, 32'h00000064);
    lk_vaddr = 32'h00012345; #1;
    check("R10 odd half hit", {31'b0, lk_hit}, 32'd1);
    check("R10 odd half paddr", lk_paddr, 32'h80012345);
    lk_vaddr = 32'h00005678; #1;
    check("R10 even half paddr", lk_paddr, 32'h80005678);
    check("R10 even half attrs", {28'b0, lk_dirty, lk_cattr}, 32'hF);
    lk_vaddr = 32'h12346ABC; #1;
    check("R10 asid mismatch no hit", {31'b0, lk_hit}, 32'd0);
    @(negedge clk);
    wr_reg(A_HI, 32'h00000011);
    lk_vaddr = 32'h12346ABC; #1;
    check("R10 small page hit", {31'b0, lk_hit}, 32'd1);
    check("R10 small page paddr", lk_paddr, 32'h00000ABC);
    lk_vaddr = 32'h12347ABC; #1;
    check("R10 invalid odd half", {31'b0, lk_hit}, 32'd0);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule